// File: doc/BRIEF.md
# Looping Vector Pattern Sequencer

This block reads a stored pattern memory one entry per drive clock and places each wide vector on its outputs. A small control word is stored alongside every vector. It can hold the sequencer on a vector until an external release arrives, mark a loop end, end driving once the repeat count is used up, or request a capture strobe for an acquisition section that samples the device under test.

Loops are set up with a loop-back address and a 16-bit repeat count. The count is written one byte at a time through a single byte port. The loop flag sits on the vector one place before the last vector of the loop body. This gives the address logic one vector period to prepare the jump, so the body repeats with no gap. A last-pass bit records that the final pass has begun. The terminate flag is honoured only while that bit is set, so the same flag can close a loop or act as a plain stop placed after it.

Software starts a run with a one-cycle start pulse and can abort it with a stop pulse. Busy and done outputs report the run state. Loading the pattern memory and qualifying the drive clock are handled outside this block.

Top module: `vec_seq_top`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o, cap_o and every bit of vec_o are 0.
- R2: When start_i is high while idle, busy_o is 1 and done_o is 0 after that edge, and memory address 0 is fetched. Its vector appears on all bits of vec_o together one edge later. start_i is ignored while busy.
- R3: With no flags involved, each advancing edge fetches the next address.
- R4: Control bit 1 (loop) on the vector at address A decrements a nonzero working count. The vector fetched after A+1 then comes from loop_addr_i. A count C gives C+1 passes of the loop body; a zero count gives no branch.
- R5: A cnt_wr_i edge writes cnt_byte_i to count bits 15:8 when cnt_hi_sel_i is 1, and to bits 7:0 otherwise. The count is copied to the working count at start.
- R6: Control bit 2 (terminate) is ignored unless the last-pass bit is set. That bit is set at start when the count is zero, and otherwise when the branch into the final pass is taken. When honoured, the next vector fetched is the last one.
- R7: While the vector on vec_o has control bit 0 (wait) set and wait_rel_i is low, the sequencer holds that vector and its address.
- R8: cap_o is control bit 3 (capture) of the vector on vec_o, ANDed with the drive clock. It is high only during the high phase of clk_i.
- R9: After the last vector has been shown, the first edge that is not held clears busy_o and sets done_o, and vec_o keeps that vector. Fetching the top memory address also makes it the last vector.
- R10: stop_i while busy clears busy_o and sets done_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Drive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| stop_i | input | 1 | Abort pulse |
| wait_rel_i | input | 1 | Releases a vector with the wait flag |
| cnt_byte_i | input | 8 | Byte for the repeat count |
| cnt_hi_sel_i | input | 1 | 1 selects the upper count byte |
| cnt_wr_i | input | 1 | Count byte write strobe |
| loop_addr_i | input | ADDR_W | Loop-back address |
| mem_addr_o | output | ADDR_W | Pattern memory read address |
| mem_vec_i | input | DATA_W | Vector read data |
| mem_ctl_i | input | 4 | Control read data: bit0 wait, bit1 loop, bit2 terminate, bit3 capture |
| vec_o | output | DATA_W | Registered output vector |
| cap_o | output | 1 | Capture strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run ended; cleared by the next start |

## Verification
busy_o and done_o change at the same edge as the start or stop pulse. The vector at address 0 is due one edge after start. Every later vector is due one edge after the previous one, unless a wait hold is active, in which case the same vector stays. The bench builds the expected vector list ahead of time from the flags and the count. It then steps a pointer through that list on each edge, using the wait_rel_i value it drove itself, and compares 2 ns after the rising edge. cap_o is checked at that point against the capture flag of the expected vector, and again 1 ns after the falling edge, where it must be low.

// File: rtl/vs_pkg.sv
`timescale 1ns/1ps
package vs_pkg;
  typedef struct packed {
    logic cap;
    logic term;
    logic loop;
    logic hold;
  } ctl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LAST} state_e;
endpackage

// File: rtl/vs_loop_cnt.sv
`timescale 1ns/1ps
module vs_loop_cnt #(
  parameter int CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       hi_sel_i,
  input  logic [7:0] byte_i,
  input  logic       load_i,
  input  logic       dec_i,
  output logic       branch_o,
  output logic       last_o
);
  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] cfg_q, cnt_q;
  logic             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      if (hi_sel_i) cfg_q[CNT_W-1:8] <= byte_i[HI_W-1:0];
      else          cfg_q[7:0]       <= byte_i;
    end
  end

  assign branch_o = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= cfg_q;
      last_q <= (cfg_q == '0);
    end else if (branch_o) begin
      cnt_q  <= cnt_q - 1'b1;
      last_q <= (cnt_q == CNT_W'(1));
    end
  end

  assign last_o = last_q;
endmodule

// File: rtl/vs_addr_gen.sv
`timescale 1ns/1ps
module vs_addr_gen #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] loop_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_top_o,
  output logic              br_pend_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              br_pend_q;

  // branch is armed one vector early, taken after the loop-end vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      br_pend_q <= 1'b0;
    end else if (load_i) begin
      addr_q    <= '0;
      br_pend_q <= 1'b0;
    end else if (adv_i) begin
      addr_q    <= br_pend_q ? loop_addr_i : addr_q + 1'b1;
      br_pend_q <= branch_i;
    end
  end

  assign addr_o    = addr_q;
  assign at_top_o  = &addr_q;
  assign br_pend_o = br_pend_q;
endmodule

// File: rtl/vs_out_stage.sv
`timescale 1ns/1ps
module vs_out_stage #(
  parameter int DATA_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] vec_i,
  input  vs_pkg::ctl_t      ctl_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              cap_o,
  output logic              hold_o
);
  logic [DATA_W-1:0] vec_q;
  logic              cap_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      cap_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (clear_i) begin
      cap_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (adv_i) begin
      vec_q  <= vec_i;
      cap_q  <= ctl_i.cap;
      hold_q <= ctl_i.hold;
    end
  end

  assign vec_o  = vec_q;
  assign cap_o  = cap_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/vec_seq_top.sv
`timescale 1ns/1ps
module vec_seq_top #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 40,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wait_rel_i,
  input  logic [7:0]        cnt_byte_i,
  input  logic              cnt_hi_sel_i,
  input  logic              cnt_wr_i,
  input  logic [ADDR_W-1:0] loop_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_vec_i,
  input  logic [3:0]        mem_ctl_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              cap_o,
  output logic              busy_o,
  output logic              done_o
);
  import vs_pkg::*;

  state_e state_q;
  logic   done_q, end_pend_q;
  ctl_t   ctl;
  logic   hold_q, cap_q, last, branch, at_top, br_pend;
  logic   stall, go, adv, to_idle, term_now;

  assign ctl      = ctl_t'(mem_ctl_i);
  assign stall    = hold_q && !wait_rel_i;
  assign go       = (state_q == ST_IDLE) && start_i;
  assign adv      = (state_q == ST_RUN) && !stop_i && !stall;
  assign to_idle  = (state_q != ST_IDLE) && (stop_i || ((state_q == ST_LAST) && !stall));
  assign term_now = ctl.term && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      done_q     <= 1'b0;
      end_pend_q <= 1'b0;
    end else begin
      if (go) begin
        state_q    <= ST_RUN;
        done_q     <= 1'b0;
        end_pend_q <= 1'b0;
      end else if (to_idle) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else if (adv) begin
        end_pend_q <= term_now;
        if (end_pend_q || at_top) state_q <= ST_LAST;
      end
    end
  end

  vs_loop_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cnt_wr_i),
    .hi_sel_i (cnt_hi_sel_i),
    .byte_i   (cnt_byte_i),
    .load_i   (go),
    .dec_i    (adv && ctl.loop),
    .branch_o (branch),
    .last_o   (last)
  );

  vs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (go),
    .adv_i       (adv),
    .branch_i    (branch),
    .loop_addr_i (loop_addr_i),
    .addr_o      (mem_addr_o),
    .at_top_o    (at_top),
    .br_pend_o   (br_pend)
  );

  vs_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (go || to_idle),
    .adv_i   (adv),
    .vec_i   (mem_vec_i),
    .ctl_i   (ctl),
    .vec_o   (vec_o),
    .cap_o   (cap_q),
    .hold_o  (hold_q)
  );

  // capture edge falls mid-period
  assign cap_o  = cap_q & clk_i;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/vs_chk.sv
`timescale 1ns/1ps
module vs_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              wait_rel_i,
  input logic [ADDR_W-1:0] loop_addr_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] vec_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              hold_q,
  input logic              br_pend
);
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && !done_o);

  assert_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && stop_i |=> !busy_o && done_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && hold_q && !wait_rel_i && !stop_i |=> busy_o && $stable(vec_o) && $stable(mem_addr_o));

  assert_branch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && br_pend |=> (mem_addr_o == $past(loop_addr_i)) || $stable(mem_addr_o));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !br_pend |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)) || $stable(mem_addr_o));

  assert_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind vec_seq_top vs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .wait_rel_i  (wait_rel_i),
  .loop_addr_i (loop_addr_i),
  .mem_addr_o  (mem_addr_o),
  .vec_o       (vec_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .hold_q      (hold_q),
  .br_pend     (br_pend)
);

// File: tb/tb_vec_seq_top.sv
`timescale 1ns/1ps
module tb_vec_seq_top;
  localparam int AW = 8;
  localparam int DW = 40;
  localparam int DEPTH = 1 << AW;
  localparam int MAXSEQ = 8192;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start_i = 0, stop_i = 0, wait_rel_i = 1;
  logic [7:0]    cnt_byte_i = 0;
  logic          cnt_hi_sel_i = 0, cnt_wr_i = 0;
  logic [AW-1:0] loop_addr_i = 0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_vec_i, vec_o;
  logic [3:0]    mem_ctl_i;
  logic          cap_o, busy_o, done_o;

  logic [3:0] ctl_mem [DEPTH];
  int seq [MAXSEQ];
  int seq_n;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] vec_of(int a);
    return {8'(a ^ 'h5A), 32'(a * 32'h9E3779B1) ^ 32'h13579BDF};
  endfunction

  assign mem_vec_i = vec_of(int'(mem_addr_o));
  assign mem_ctl_i = ctl_mem[mem_addr_o];

  vec_seq_top #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .stop_i(stop_i),
    .wait_rel_i(wait_rel_i), .cnt_byte_i(cnt_byte_i), .cnt_hi_sel_i(cnt_hi_sel_i),
    .cnt_wr_i(cnt_wr_i), .loop_addr_i(loop_addr_i), .mem_addr_o(mem_addr_o),
    .mem_vec_i(mem_vec_i), .mem_ctl_i(mem_ctl_i), .vec_o(vec_o), .cap_o(cap_o),
    .busy_o(busy_o), .done_o(done_o));

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected fetch order from flags, count and loop-back address
  task automatic build_seq(int c, int l);
    int a = 0, cnt = c;
    bit last = (c == 0), br = 0, endp = 0, tn;
    int nxt;
    seq_n = 0;
    forever begin
      seq[seq_n] = a;
      seq_n++;
      if (endp || a == DEPTH - 1 || seq_n >= MAXSEQ) break;
      nxt = br ? l : a + 1;
      tn  = ctl_mem[a][2] && last;
      br  = 0;
      if (ctl_mem[a][1] && cnt != 0) begin
        cnt--;
        br = 1;
        last = (cnt == 0);
      end
      endp = tn;
      a = nxt;
    end
  endtask

  task automatic set_count(int c);
    @(negedge clk); cnt_byte_i = 8'(c);      cnt_hi_sel_i = 0; cnt_wr_i = 1;
    @(negedge clk); cnt_byte_i = 8'(c >> 8); cnt_hi_sel_i = 1;
    @(negedge clk); cnt_wr_i = 0;
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(posedge clk); #2;
    check(busy_o === 1'b1 && done_o === 1'b0, "R2 start", {busy_o, done_o}, 2'b10);
    @(negedge clk); start_i = 0;
  endtask

  task automatic run(int c, int l, string tag, bit rnd_wait);
    int j = 0;
    bit stall;
    loop_addr_i = AW'(l);
    set_count(c);
    build_seq(c, l);
    @(negedge clk); start_i = 1;
    @(posedge clk); #2;
    check(busy_o === 1'b1 && done_o === 1'b0, "R2 start", {busy_o, done_o}, 2'b10);
    @(negedge clk); start_i = 0;
    @(posedge clk); #2;
    check(vec_o === vec_of(seq[0]), "R2 first vector", vec_o, vec_of(seq[0]));
    while (!ended) begin
      @(negedge clk);
      wait_rel_i = rnd_wait ? 1'($urandom % 2) : 1'b1;
      #1 check(cap_o === 1'b0, "R8 low phase", cap_o, 0);
      @(posedge clk); #2;
      stall = ctl_mem[seq[j]][0] && !wait_rel_i;
      if (!stall) begin
        if (j == seq_n - 1) begin
          check(busy_o === 1'b0 && done_o === 1'b1, "R9 end", {busy_o, done_o}, 2'b01);
          check(vec_o === vec_of(seq[j]), "R9 hold", vec_o, vec_of(seq[j]));
          break;
        end
        j++;
      end
      check(busy_o === 1'b1, stall ? "R7 held busy" : "R3 busy", busy_o, 1);
      check(vec_o === vec_of(seq[j]), stall ? "R7 hold" : tag, vec_o, vec_of(seq[j]));
      check(cap_o === ctl_mem[seq[j]][3], "R8 strobe", cap_o, ctl_mem[seq[j]][3]);
    end
    @(negedge clk); wait_rel_i = 1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) ctl_mem[i] = 4'h0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    clear_mem();
    #22;
    check(busy_o === 0 && done_o === 0 && cap_o === 0 && vec_o === '0, "R1 in reset",
          {busy_o, done_o, cap_o, |vec_o}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    check(busy_o === 0 && done_o === 0 && vec_o === '0, "R1 after reset",
          {busy_o, done_o, |vec_o}, 0);

    // plain walk to the top address
    run(0, 0, "R3", 0);

    // R4 R5: short body, count with both bytes
    clear_mem();
    ctl_mem[4] = 4'b0110; ctl_mem[3] = 4'b1000;
    run(16'h0103, 3, "R5", 0);

    // R6: terminate ignored before the last pass; stop after loop end
    clear_mem();
    ctl_mem[1] = 4'b0100; ctl_mem[4] = 4'b0010; ctl_mem[7] = 4'b0100;
    run(3, 0, "R6", 0);

    // R6: zero count, terminate on loop-flag vector honoured at once
    clear_mem();
    ctl_mem[2] = 4'b0110;
    run(0, 0, "R6", 0);

    // R7: directed wait with random release
    clear_mem();
    ctl_mem[1] = 4'b1001; ctl_mem[2] = 4'b0101;
    ctl_mem[0] = 4'b0100;
    run(0, 0, "R7", 1);

    // random programs
    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctl_mem[i] = 4'h0;
        if ($urandom % 4 == 0)  ctl_mem[i][3] = 1;
        if ($urandom % 8 == 0)  ctl_mem[i][0] = 1;
        if ($urandom % 16 == 0) ctl_mem[i][1] = 1;
        if ($urandom % 16 == 0) ctl_mem[i][2] = 1;
      end
      run(int'($urandom % 6), int'($urandom % DEPTH), "R4", 1);
    end

    // R10: abort, R2: start ignored while busy
    clear_mem();
    loop_addr_i = 0;
    set_count(0);
    do_start();
    repeat (3) @(negedge clk);
    start_i = 1;
    @(posedge clk); #2;
    check(busy_o === 1'b1 && done_o === 1'b0, "R2 start ignored", {busy_o, done_o}, 2'b10);
    @(negedge clk); start_i = 0; stop_i = 1;
    @(posedge clk); #2;
    check(busy_o === 1'b0 && done_o === 1'b1, "R10 abort", {busy_o, done_o}, 2'b01);
    @(negedge clk); stop_i = 0;
    @(posedge clk); #2;
    check(done_o === 1'b1 && busy_o === 1'b0, "R10 stays done", {busy_o, done_o}, 2'b01);

    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule